// File: doc/BRIEF.md
# Serial Character Receiver with Fill-Level Flow Control

This block receives asynchronous serial characters on a single line and delivers them, oldest first, through a valid/ready byte stream that drains an internal 16-entry buffer. The line is oversampled 16 times per bit. The oversampling rate comes from a baud-tick enable input that is generated outside the block. A character is a low start bit, eight data bits sent least significant first, an optional parity bit, and one high stop bit.

A request-to-send output (`rts_n`, active low) tells the far end whether more characters may be sent. It goes high when the buffer fill reaches a threshold chosen by a 3-bit select. It is also forced high while reception is disabled.

Status flags report the following conditions:
- a character has arrived;
- the stop bit was wrong;
- the parity bit was wrong;
- a character was lost because the buffer was full.

Two interrupt requests are derived from these flags: one for data and one for errors. Single-cycle clear inputs reset the flags.

The output stream follows these rules. `rd_valid` is high whenever the buffer holds at least one byte. A byte is removed only in a cycle where `rd_valid` and `rd_ready` are both high. While `rd_valid` is high and `rd_ready` is low, `rd_data` is held. The receive side has no back-pressure: a character that completes while the buffer is full is dropped.

Top module: `uart_rx_fc`

## Requirements
- R1: A character is 1 start bit (0), data bits D0 first through D7, an optional parity bit, and 1 stop bit (1). The received bytes leave on `rd_data` in arrival order.
- R2: A falling edge counts as a start bit only if the line is still low at the mid-bit sample, 8 ticks later. A shorter low pulse stores nothing.
- R3: When `par_en`=1, the expected parity bit is the XOR of the data bits for even parity (`par_odd`=0), and its inverse for odd parity (`par_odd`=1). A mismatch sets `per`.
- R4: A stop bit sampled as 0 sets `fer`. The character is still stored.
- R5: `rdf` is set when a character is stored, and is cleared by a `clr_rdf` pulse. `data_irq` equals `rdf` AND `rie`.
- R6: `err_irq` equals (`fer` OR `per` OR `ovr`) AND `eie`. A `clr_err` pulse clears all three error flags.
- R7: The buffer holds 16 bytes. A character that completes while 16 bytes are held is discarded, and `ovr` is set.
- R8: When `rx_en`=1 and `fc_en`=1, `rts_n` is 1 if `rd_count` is greater than or equal to the trigger, and 0 otherwise. The trigger for `rts_sel` values 0..7 is 1, 2, 4, 6, 8, 10, 12, 14. When `fc_en`=0 and `rx_en`=1, `rts_n` is 0.
- R9: When `rx_en`=0, `rts_n` is 1 and activity on the line stores nothing.
- R10: A byte is popped only in a cycle where `rd_valid` and `rd_ready` are both high. `rd_count` changes by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Oversampling enable, 16 per bit time |
| rx | input | 1 | Serial receive line, idle high |
| rx_en | input | 1 | Reception enable |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| fc_en | input | 1 | Flow control enable |
| rts_sel | input | 3 | Flow-control trigger select |
| rie | input | 1 | Data interrupt enable |
| eie | input | 1 | Error interrupt enable |
| clr_rdf | input | 1 | Clear data-ready flag |
| clr_err | input | 1 | Clear error flags |
| rd_valid | output | 1 | Buffer not empty |
| rd_ready | input | 1 | Consumer accepts the head byte |
| rd_data | output | 8 | Head byte of the buffer |
| rd_count | output | 5 | Bytes held |
| rdf | output | 1 | Data-ready flag |
| fer | output | 1 | Framing error flag |
| per | output | 1 | Parity error flag |
| ovr | output | 1 | Overrun flag |
| data_irq | output | 1 | Data interrupt request |
| err_irq | output | 1 | Error interrupt request |
| rts_n | output | 1 | Request to send, active low |

## Verification
The assertions assume three things about the inputs:
- `par_en` and `par_odd` are held steady for the whole duration of a character;
- the clear pulses are single cycles;
- `rd_ready` may be asserted at any time.

The stimulus meets these assumptions. Parity settings change only while the line is idle between characters. The baud tick is held at 1, which keeps every bit exactly 16 cycles long. Every line transition is driven at the falling clock edge. Deliberate faults (a short start glitch, a flipped parity bit, a stop bit held low) are injected only as whole-character patterns.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  // Fill level at which the sender is asked to pause.
  function automatic int unsigned trig_level(input logic [2:0] sel);
    return (sel == 3'd0) ? 1 : 2 * int'(sel);
  endfunction

endpackage

// File: rtl/rx_deframer.sv
module rx_deframer
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx_in,
  input  logic          enable,
  input  logic          par_en,
  input  logic          par_odd,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          ferr,
  output logic          perr
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DW + 1);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [BW-1:0] LASTBIT = BW'(DW - 1);

  rx_state_e     state;
  logic          rx_m, rx_s;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [DW-1:0] shreg;
  logic          par_bit;

  // Two-flop synchronizer, idle high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rx_in;
      rx_s <= rx_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
      done    <= 1'b0;
      ferr    <= 1'b0;
      perr    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!enable) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else if (tick) begin
        cnt <= cnt + 1'b1;
        unique case (state)
          ST_IDLE: begin
            cnt <= '0;
            if (!rx_s) state <= ST_START;
          end
          ST_START: begin
            if (cnt == MID) begin
              cnt  <= '0;
              bitn <= '0;
              state <= rx_s ? ST_IDLE : ST_DATA;
            end
          end
          ST_DATA: begin
            if (cnt == LAST) begin
              shreg <= {rx_s, shreg[DW-1:1]};
              bitn  <= bitn + 1'b1;
              if (bitn == LASTBIT) state <= par_en ? ST_PAR : ST_STOP;
            end
          end
          ST_PAR: begin
            if (cnt == LAST) begin
              par_bit <= rx_s;
              state   <= ST_STOP;
            end
          end
          ST_STOP: begin
            if (cnt == LAST) begin
              done  <= 1'b1;
              ferr  <= ~rx_s;
              perr  <= par_en & (par_bit != ((^shreg) ^ par_odd));
              state <= ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign data = shreg;

endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DW-1:0]              wdata,
  input  logic                       pop,
  output logic [DW-1:0]              rdata,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;

  wire do_push = push & ~full;
  wire do_pop  = pop & ~empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  assign rdata = mem[rp];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

endmodule

// File: rtl/rts_ctrl.sv
module rts_ctrl
  import uart_rx_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic [CW-1:0] level,
  input  logic [2:0]    sel,
  input  logic          rx_en,
  input  logic          fc_en,
  output logic          rts_n
);
  always_comb begin
    if (!rx_en)      rts_n = 1'b1;
    else if (!fc_en) rts_n = 1'b0;
    else             rts_n = (32'(level) >= trig_level(sel));
  end
endmodule

// File: rtl/uart_rx_fc.sv
module uart_rx_fc
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OVS   = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          rx,
  input  logic          rx_en,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          fc_en,
  input  logic [2:0]    rts_sel,
  input  logic          rie,
  input  logic          eie,
  input  logic          clr_rdf,
  input  logic          clr_err,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] rd_count,
  output logic          rdf,
  output logic          fer,
  output logic          per,
  output logic          ovr,
  output logic          data_irq,
  output logic          err_irq,
  output logic          rts_n
);
  logic          fr_done, fr_ferr, fr_perr;
  logic [DW-1:0] fr_data;
  logic          full, empty;

  rx_deframer #(.OVS(OVS), .DW(DW)) u_deframer (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rx_in(rx), .enable(rx_en),
    .par_en(par_en), .par_odd(par_odd), .done(fr_done), .data(fr_data),
    .ferr(fr_ferr), .perr(fr_perr)
  );

  wire push = fr_done & ~full;
  wire drop = fr_done & full;

  rx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .wdata(fr_data),
    .pop(rd_valid & rd_ready), .rdata(rd_data), .count(rd_count),
    .full(full), .empty(empty)
  );

  rts_ctrl #(.CW(CW)) u_rts (
    .level(rd_count), .sel(rts_sel), .rx_en(rx_en), .fc_en(fc_en), .rts_n(rts_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdf <= 1'b0;
      fer <= 1'b0;
      per <= 1'b0;
      ovr <= 1'b0;
    end else begin
      if (push)         rdf <= 1'b1;
      else if (clr_rdf) rdf <= 1'b0;
      if (fr_done && fr_ferr) fer <= 1'b1;
      else if (clr_err)       fer <= 1'b0;
      if (fr_done && fr_perr) per <= 1'b1;
      else if (clr_err)       per <= 1'b0;
      if (drop)         ovr <= 1'b1;
      else if (clr_err) ovr <= 1'b0;
    end
  end

  assign rd_valid = ~empty;
  assign data_irq = rdf & rie;
  assign err_irq  = (fer | per | ovr) & eie;

endmodule

// File: rtl/uart_rx_fc_chk.sv
module uart_rx_fc_chk
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          fc_en,
  input logic [2:0]    rts_sel,
  input logic          eie,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [DW-1:0] rd_data,
  input logic [CW-1:0] rd_count,
  input logic          rdf,
  input logic          ovr,
  input logic          err_irq,
  input logic          rts_n
);
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rd_count) <= DEPTH);

  assert_ovr_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> 32'($past(rd_count)) == DEPTH);

  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_count == $past(rd_count)) || (rd_count == $past(rd_count) + 1'b1) ||
    (rd_count == $past(rd_count) - 1'b1));

  assert_hold_head_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> $stable(rd_data));

  assert_rdf_has_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdf) |-> rd_valid);

  assert_err_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> eie);

  assert_rts_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> rts_n);

  assert_rts_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && fc_en && 32'(rd_count) < trig_level(rts_sel)) |-> !rts_n);
endmodule

bind uart_rx_fc uart_rx_fc_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .fc_en(fc_en), .rts_sel(rts_sel),
  .eie(eie), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .rd_count(rd_count), .rdf(rdf), .ovr(ovr), .err_irq(err_irq), .rts_n(rts_n)
);

// File: tb/tb_uart_rx_fc.sv
module tb_uart_rx_fc;
  logic clk = 1'b0, rst_n = 1'b0;
  logic baud_tick = 1'b1, rx = 1'b1, rx_en = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic fc_en = 1'b1, rie = 1'b1, eie = 1'b1, clr_rdf = 1'b0, clr_err = 1'b0, rd_ready = 1'b0;
  logic [2:0] rts_sel = 3'd7;
  logic rd_valid, rdf, fer, per, ovr, data_irq, err_irq, rts_n;
  logic [7:0] rd_data;
  logic [4:0] rd_count;

  int n_chk = 0, n_fail = 0;
  logic [7:0] expq[$];

  always #4 clk = ~clk;

  uart_rx_fc dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx(rx), .rx_en(rx_en),
    .par_en(par_en), .par_odd(par_odd), .fc_en(fc_en), .rts_sel(rts_sel),
    .rie(rie), .eie(eie), .clr_rdf(clr_rdf), .clr_err(clr_err),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_count(rd_count), .rdf(rdf), .fer(fer), .per(per), .ovr(ovr),
    .data_irq(data_irq), .err_irq(err_irq), .rts_n(rts_n)
  );

  function automatic int trig_of(input int sel);
    return (sel == 0) ? 1 : 2 * sel;
  endfunction

  function automatic logic par_of(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic hold_line(input logic v, input int n);
    rx = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    hold_line(1'b0, 16);
    for (int i = 0; i < 8; i++) hold_line(d[i], 16);
    if (par_en) hold_line(par_of(d, par_odd) ^ bad_par, 16);
    if (bad_stop) hold_line(1'b0, 10);
    hold_line(1'b1, 24);
  endtask

  task automatic pop_chk(input string req);
    logic [7:0] e;
    e = expq.pop_front();
    chk(rd_valid === 1'b1, req, int'(rd_valid), 1);
    chk(rd_data === e, req, int'(rd_data), int'(e));
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state; disabled receiver holds rts high (R9)
    chk(rd_valid == 0 && rdf == 0 && fer == 0 && per == 0 && ovr == 0, "R5 reset", int'(rdf), 0);
    chk(rts_n == 1, "R9 rts while disabled", int'(rts_n), 1);
    send(8'h5A, 0, 0);
    chk(rd_count == 0, "R9 line ignored when disabled", int'(rd_count), 0);

    rx_en = 1'b1;
    @(negedge clk);
    chk(rts_n == 0, "R8 rts low when empty", int'(rts_n), 0);

    // Random characters with random parity setup (R1, R3, R5)
    for (int k = 0; k < 6; k++) begin
      d = 8'($urandom);
      par_en = 1'($urandom);
      par_odd = 1'($urandom);
      rie = 1'($urandom);
      send(d, 0, 0);
      expq.push_back(d);
      chk(rdf == 1, "R5 rdf set", int'(rdf), 1);
      chk(data_irq == rie, "R5 data_irq", int'(data_irq), int'(rie));
      chk(per == 0 && fer == 0, "R3 no error on good char", int'({fer, per}), 0);
      pop_chk("R1 data order");
      pulse(clr_rdf);
      chk(rdf == 0, "R5 rdf clear", int'(rdf), 0);
    end
    rie = 1'b1;

    // Short start glitch (R2)
    hold_line(1'b0, 4);
    hold_line(1'b1, 200);
    chk(rd_count == 0, "R2 glitch ignored", int'(rd_count), 0);

    // Bad parity, even then odd (R3, R6)
    for (int o = 0; o < 2; o++) begin
      par_en = 1'b1;
      par_odd = 1'(o);
      send(8'hC3, 1, 0);
      expq.push_back(8'hC3);
      chk(per == 1, "R3 parity mismatch", int'(per), 1);
      chk(err_irq == 1, "R6 err_irq on per", int'(err_irq), 1);
      eie = 1'b0;
      @(negedge clk);
      chk(err_irq == 0, "R6 err_irq gated", int'(err_irq), 0);
      eie = 1'b1;
      pop_chk("R1 data with bad parity");
      pulse(clr_err);
      chk(per == 0 && err_irq == 0, "R6 clr_err", int'(per), 0);
    end
    par_en = 1'b0;

    // Framing error (R4)
    send(8'h81, 0, 1);
    expq.push_back(8'h81);
    chk(fer == 1, "R4 fer on low stop", int'(fer), 1);
    chk(rd_count == 1, "R4 char stored", int'(rd_count), 1);
    // Hold without ready (R10)
    repeat (5) @(negedge clk);
    chk(rd_count == 1 && rd_data == 8'h81, "R10 no pop without ready", int'(rd_count), 1);
    pop_chk("R4 data");
    pulse(clr_err);

    // Fill to full, checking rts at every select (R7, R8)
    for (int k = 0; k < 16; k++) begin
      d = 8'($urandom);
      send(d, 0, 0);
      expq.push_back(d);
      for (int s = 0; s < 8; s++) begin
        rts_sel = 3'(s);
        #1;
        chk(rts_n == (k + 1 >= trig_of(s)), "R8 rts threshold", int'(rts_n),
            int'(k + 1 >= trig_of(s)));
      end
    end
    fc_en = 1'b0;
    #1;
    chk(rts_n == 0, "R8 fc disabled", int'(rts_n), 0);
    fc_en = 1'b1;
    chk(ovr == 0, "R7 no overrun yet", int'(ovr), 0);
    send(8'hEE, 0, 0);
    chk(ovr == 1, "R7 overrun flag", int'(ovr), 1);
    chk(rd_count == 16, "R7 count stays 16", int'(rd_count), 16);
    chk(err_irq == 1, "R6 err_irq on ovr", int'(err_irq), 1);
    rx_en = 1'b0;
    #1;
    chk(rts_n == 1, "R9 rts forced high", int'(rts_n), 1);
    rx_en = 1'b1;
    while (expq.size() > 0) pop_chk("R7 order after overrun");
    chk(rd_valid == 0, "R10 empty after drain", int'(rd_valid), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule